// File: doc/BRIEF.md
# I2C Burst Transmit Master

This block drives an I2C bus as a master and sends one burst of bytes that software has placed in a small word-addressed transmit buffer. Software first enables the block in transmit mode. It may then ask for a START condition and fill up to eight 32-bit buffer words. Writing a byte count launches the burst. Byte 0 of the buffer is the address byte: the 7-bit target address shifted up one place, with the read/write bit clear. A STOP condition is requested the same way as a START.

Every bus event leaves a pending bit. Each pending bit has an enable bit in the same position, and the interrupt line is raised when an enabled bit is pending. Both bus lines are driven open-drain: an output of 1 pulls the line low. SDA is read back through a synchronizer to sample the target's acknowledge. The SCL period is four phases of `QUARTER` clock cycles each.

Register word addresses: 0 control, 1 byte count, 2 interrupt enable, 3 pending. Addresses 8 to 15 hold transmit buffer words 0 to 7, which are write-only and read as 0. Read data is registered and appears one cycle after the address.

Top module: `i2c_burst_tx`

## Requirements
- R1: After reset, both line drives are released, `irq` is low, and the control, count, enable and pending registers read 0.
- R2: A control write with bit 0 (enable) set that raises bit 3 (start request) makes SDA fall while SCL is high. Pending bit 4 is then set and SCL is held low. The request bit keeps its value until software clears it.
- R3: With bit 0 set and control bits 2:1 equal to 0 (transmit), a nonzero write to the count register sends that many buffer bytes, MSB first. Byte k is bits 8*(k%4)+7 to 8*(k%4) of word k/4. Every acknowledged byte sets pending bit 0, and the last one also sets pending bit 2.
- R4: Outside a START or STOP condition, SDA changes only while SCL is low. The acknowledge is sampled in the high phase of the ninth clock.
- R5: A count above 32 sends 32 bytes, and a count of 0 starts nothing and sets no pending bit.
- R6: A byte that is not acknowledged sets pending bit 6 and ends the burst. No further byte is sent and pending bit 2 stays clear.
- R7: A control write with bit 0 set that raises bit 4 (stop request) makes SDA rise while SCL is high. Pending bit 5 is then set and both lines are released.
- R8: Pending bits are cleared by writing 1 to them at address 3. Writing 0 leaves a bit unchanged.
- R9: One cycle after any pending bit is set together with its enable bit at address 2 (same position), `irq` is high. When no enable bit is set, `irq` stays low.
- R10: Writing control bit 0 as 0 aborts any activity and releases both lines by the next cycle. A burst that was running does not set pending bit 2.
- R11: A count write while control bits 2:1 are not 0 is ignored: no bus activity and no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| irq | output | 1 | Interrupt, any enabled pending bit |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The checker assumes that `sda_in` comes only from the resolved open-drain line. It also assumes that a target changes SDA only while SCL is low, so that acknowledge samples and the SDA stability rule depend on the master's phases alone. The bench target model pulls SDA only in the low phase after the eighth clock and lets go at the next falling edge. The bench changes bus registers only between whole operations, with one exception: the disable write, which deliberately lands in the middle of a byte.

// File: rtl/i2c_btx_pkg.sv
package i2c_btx_pkg;
  localparam int A_CTRL  = 0;
  localparam int A_COUNT = 1;
  localparam int A_IEN   = 2;
  localparam int A_PEND  = 3;

  localparam int EV_BYTE  = 0;
  localparam int EV_BURST = 2;
  localparam int EV_START = 4;
  localparam int EV_STOP  = 5;
  localparam int EV_NAK   = 6;

  localparam logic [6:0] PEND_MASK = 7'b111_0101;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_FETCH,
    SQ_BIT,
    SQ_STOP
  } sq_state_e;
endpackage

// File: rtl/i2c_btx_regs.sv
module i2c_btx_regs
  import i2c_btx_pkg::*;
#(
  parameter int BUF_WORDS = 8,
  localparam int IDX_W  = $clog2(BUF_WORDS),
  localparam int ADDR_W = IDX_W + 1,
  localparam int MAXB   = BUF_WORDS * 4,
  localparam int CNT_W  = $clog2(MAXB) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              enable,
  output logic [6:0]        pend,
  output logic [6:0]        ien,
  input  logic [6:0]        ev_set,
  output logic              start_go,
  output logic              stop_go,
  output logic              burst_go,
  output logic [CNT_W-1:0]  burst_len,
  input  logic [IDX_W-1:0]  buf_ridx,
  output logic [31:0]       buf_rdata
);
  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(A_COUNT);
  localparam logic [ADDR_W-1:0] AD_IEN   = ADDR_W'(A_IEN);
  localparam logic [ADDR_W-1:0] AD_PEND  = ADDR_W'(A_PEND);

  logic [6:0]       ctrl_q;
  logic [6:0]       ien_q;
  logic [6:0]       pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      mem [BUF_WORDS];

  logic is_buf, wr_ctrl, wr_cnt, wr_ien, wr_pend, wr_buf;
  logic [CNT_W-1:0] cnt_in;

  assign is_buf  = bus_addr[ADDR_W-1];
  assign wr_ctrl = bus_wr && (bus_addr == AD_CTRL);
  assign wr_cnt  = bus_wr && (bus_addr == AD_COUNT);
  assign wr_ien  = bus_wr && (bus_addr == AD_IEN);
  assign wr_pend = bus_wr && (bus_addr == AD_PEND);
  assign wr_buf  = bus_wr && is_buf;
  assign cnt_in  = bus_wdata[CNT_W-1:0];

  // command pulses: request bits act on their rising value only
  assign start_go  = wr_ctrl && bus_wdata[0] && bus_wdata[3] && !ctrl_q[3];
  assign stop_go   = wr_ctrl && bus_wdata[0] && bus_wdata[4] && !ctrl_q[4];
  assign burst_go  = wr_cnt && ctrl_q[0] && (ctrl_q[2:1] == 2'd0) && (cnt_in != '0);
  assign burst_len = (cnt_in > CNT_W'(MAXB)) ? CNT_W'(MAXB) : cnt_in;

  assign enable = ctrl_q[0];
  assign pend   = pend_q;
  assign ien    = ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      pend_q    <= '0;
      cnt_q     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[6:0];
      if (wr_ien)  ien_q  <= bus_wdata[6:0] & PEND_MASK;
      if (wr_cnt)  cnt_q  <= cnt_in;
      pend_q <= (pend_q & ~(wr_pend ? bus_wdata[6:0] : 7'd0)) | (ev_set & PEND_MASK);
      irq    <= |(pend_q & ien_q);
      if (is_buf) begin
        bus_rdata <= '0;
      end else begin
        case (bus_addr)
          AD_CTRL:  bus_rdata <= {25'd0, ctrl_q};
          AD_COUNT: bus_rdata <= {{(32-CNT_W){1'b0}}, cnt_q};
          AD_IEN:   bus_rdata <= {25'd0, ien_q};
          AD_PEND:  bus_rdata <= {25'd0, pend_q};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  // transmit buffer: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_buf) mem[bus_addr[IDX_W-1:0]] <= bus_wdata;
    buf_rdata <= mem[buf_ridx];
  end
endmodule

// File: rtl/i2c_btx_seq.sv
module i2c_btx_seq
  import i2c_btx_pkg::*;
#(
  parameter int QUARTER = 6,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 6,
  localparam int QW     = $clog2(QUARTER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start_go,
  input  logic             stop_go,
  input  logic             burst_go,
  input  logic [CNT_W-1:0] burst_len,
  output logic [IDX_W-1:0] buf_ridx,
  input  logic [31:0]      buf_rdata,
  input  logic             sda_sync,
  output logic             scl_drv,
  output logic             sda_drv,
  output logic             in_cond,
  output logic [6:0]       ev_set
);
  sq_state_e        st;
  logic [1:0]       ph;
  logic [QW-1:0]    qcnt;
  logic             held;
  logic             req_start, req_stop, req_burst;
  logic [CNT_W-1:0] req_len, len_q, bidx;
  logic [7:0]       shreg;
  logic [3:0]       bitn;
  logic             ack_bad;
  logic             fetch_wait;
  logic             tick, ph_end;

  assign tick     = (qcnt == QW'(QUARTER - 1));
  assign ph_end   = tick && (ph == 2'd3);
  assign buf_ridx = bidx[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      ph         <= '0;
      qcnt       <= '0;
      held       <= 1'b0;
      req_start  <= 1'b0;
      req_stop   <= 1'b0;
      req_burst  <= 1'b0;
      req_len    <= '0;
      len_q      <= '0;
      bidx       <= '0;
      shreg      <= '0;
      bitn       <= '0;
      ack_bad    <= 1'b0;
      fetch_wait <= 1'b0;
      ev_set     <= '0;
    end else begin
      ev_set <= '0;
      if (!enable) begin
        st        <= SQ_IDLE;
        ph        <= '0;
        qcnt      <= '0;
        held      <= 1'b0;
        req_start <= 1'b0;
        req_stop  <= 1'b0;
        req_burst <= 1'b0;
      end else begin
        case (st)
          SQ_IDLE: begin
            ph   <= '0;
            qcnt <= '0;
            if (req_start) begin
              st        <= SQ_START;
              req_start <= 1'b0;
            end else if (req_burst) begin
              st         <= SQ_FETCH;
              req_burst  <= 1'b0;
              len_q      <= req_len;
              bidx       <= '0;
              fetch_wait <= 1'b1;
            end else if (req_stop) begin
              st       <= SQ_STOP;
              req_stop <= 1'b0;
            end
          end
          SQ_FETCH: begin
            if (fetch_wait) begin
              fetch_wait <= 1'b0;
            end else begin
              shreg <= buf_rdata[8*bidx[1:0] +: 8];
              bitn  <= '0;
              ph    <= '0;
              qcnt  <= '0;
              st    <= SQ_BIT;
            end
          end
          SQ_START, SQ_STOP, SQ_BIT: begin
            if (tick) begin
              qcnt <= '0;
              ph   <= ph + 2'd1;
            end else begin
              qcnt <= qcnt + 1'b1;
            end
            if (st == SQ_BIT && tick && ph == 2'd2 && bitn == 4'd8) ack_bad <= sda_sync;
            if (ph_end) begin
              if (st == SQ_START) begin
                ev_set[EV_START] <= 1'b1;
                held             <= 1'b1;
                st               <= SQ_IDLE;
              end else if (st == SQ_STOP) begin
                ev_set[EV_STOP] <= 1'b1;
                held            <= 1'b0;
                st              <= SQ_IDLE;
              end else if (bitn != 4'd8) begin
                held  <= 1'b1;
                bitn  <= bitn + 4'd1;
                shreg <= {shreg[6:0], 1'b0};
              end else if (ack_bad) begin
                ev_set[EV_NAK] <= 1'b1;
                st             <= SQ_IDLE;
              end else begin
                ev_set[EV_BYTE] <= 1'b1;
                if (bidx == len_q - 1'b1) begin
                  ev_set[EV_BURST] <= 1'b1;
                  st               <= SQ_IDLE;
                end else begin
                  bidx       <= bidx + 1'b1;
                  fetch_wait <= 1'b1;
                  st         <= SQ_FETCH;
                end
              end
            end
          end
          default: st <= SQ_IDLE;
        endcase
      end
      // requests are latched last so a new one wins over a same-cycle clear
      if (start_go) req_start <= 1'b1;
      if (stop_go)  req_stop  <= 1'b1;
      if (burst_go) begin
        req_burst <= 1'b1;
        req_len   <= burst_len;
      end
    end
  end

  // desired line drives, 1 = pull low
  logic scl_raw, sda_raw;
  always_comb begin
    scl_raw = held;
    sda_raw = 1'b0;
    in_cond = 1'b0;
    case (st)
      SQ_START: begin
        in_cond = 1'b1;
        case (ph)
          2'd0:    begin scl_raw = held; sda_raw = 1'b0; end
          2'd1:    begin scl_raw = 1'b0; sda_raw = 1'b0; end
          2'd2:    begin scl_raw = 1'b0; sda_raw = 1'b1; end
          default: begin scl_raw = 1'b1; sda_raw = 1'b1; end
        endcase
      end
      SQ_STOP: begin
        in_cond = 1'b1;
        case (ph)
          2'd0:    begin scl_raw = 1'b1; sda_raw = 1'b1; end
          2'd1:    begin scl_raw = 1'b0; sda_raw = 1'b1; end
          default: begin scl_raw = 1'b0; sda_raw = 1'b0; end
        endcase
      end
      SQ_BIT: begin
        scl_raw = (ph == 2'd0) || (ph == 2'd3);
        sda_raw = (bitn == 4'd8) ? 1'b0 : !shreg[7];
      end
      default: begin
        scl_raw = held;
        sda_raw = 1'b0;
      end
    endcase
  end

  assign scl_drv = enable && scl_raw;
  assign sda_drv = enable && sda_raw;
endmodule

// File: rtl/i2c_btx_pad.sv
module i2c_btx_pad #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_drv,
  input  logic sda_drv,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic sda_sync
);
  logic [SYNC_STAGES-1:0] sy;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      sy     <= '1;
    end else begin
      scl_oe <= scl_drv;
      sda_oe <= sda_drv;
      sy     <= {sy[SYNC_STAGES-2:0], sda_in};
    end
  end

  assign sda_sync = sy[SYNC_STAGES-1];
endmodule

// File: rtl/i2c_burst_tx.sv
module i2c_burst_tx
  import i2c_btx_pkg::*;
#(
  parameter int BUF_WORDS   = 8,
  parameter int QUARTER     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W  = $clog2(BUF_WORDS),
  localparam int ADDR_W = IDX_W + 1,
  localparam int CNT_W  = $clog2(BUF_WORDS * 4) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic             enable;
  logic [6:0]       pend, ien, ev_set;
  logic             start_go, stop_go, burst_go;
  logic [CNT_W-1:0] burst_len;
  logic [IDX_W-1:0] buf_ridx;
  logic [31:0]      buf_rdata;
  logic             sda_sync, scl_drv, sda_drv, in_cond;

  i2c_btx_regs #(.BUF_WORDS(BUF_WORDS)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .enable(enable), .pend(pend), .ien(ien), .ev_set(ev_set),
    .start_go(start_go), .stop_go(stop_go), .burst_go(burst_go),
    .burst_len(burst_len), .buf_ridx(buf_ridx), .buf_rdata(buf_rdata)
  );

  i2c_btx_seq #(.QUARTER(QUARTER), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .start_go(start_go),
    .stop_go(stop_go), .burst_go(burst_go), .burst_len(burst_len),
    .buf_ridx(buf_ridx), .buf_rdata(buf_rdata), .sda_sync(sda_sync),
    .scl_drv(scl_drv), .sda_drv(sda_drv), .in_cond(in_cond), .ev_set(ev_set)
  );

  i2c_btx_pad #(.SYNC_STAGES(SYNC_STAGES)) u_pad (
    .clk(clk), .rst(rst), .scl_drv(scl_drv), .sda_drv(sda_drv),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_sync(sda_sync)
  );
endmodule

// File: rtl/i2c_btx_chk.sv
module i2c_btx_chk
  import i2c_btx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [6:0]        pend,
  input logic [6:0]        ien,
  input logic [6:0]        ev_set,
  input logic              irq,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              in_cond
);
  logic aborted;
  always_ff @(posedge clk) begin
    if (rst) aborted <= 1'b0;
    else if (ev_set[EV_NAK]) aborted <= 1'b1;
    else if (bus_wr && bus_addr == ADDR_W'(A_COUNT)) aborted <= 1'b0;
  end

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> $past(in_cond)); // R4

  AST_NO_BYTE_AFTER_NAK: assert property (@(posedge clk) disable iff (rst)
    aborted |-> !ev_set[EV_BYTE]); // R6

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_set[EV_NAK], ev_set[EV_STOP], ev_set[EV_START], ev_set[EV_BYTE]})); // R6

  AST_BURST_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
    ev_set[EV_BURST] |-> ev_set[EV_BYTE]); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_PEND) && ev_set == 7'd0) |=> ((pend & $past(bus_wdata[6:0])) == 7'd0)); // R8

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ($past(ien) == 7'd0) |-> !irq); // R9

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_oe && !sda_oe)); // R10
endmodule

bind i2c_burst_tx i2c_btx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pend(pend), .ien(ien), .ev_set(ev_set), .irq(irq),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .in_cond(in_cond)
);

// File: tb/i2c_burst_tx_tb_top.sv
`timescale 1ns/1ps
module i2c_burst_tx_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq, scl_oe, sda_oe;
  logic          slv_pull = 1'b0;

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_pull);

  i2c_burst_tx dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int n_chk = 0;
  int n_bad = 0;

  // target model
  int         clr_req = 0;
  int         clr_ack = 0;
  int         nak_at = -1;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  int         bitc = 0;
  logic [7:0] sh = '0;
  logic       acking = 1'b0;
  int         nbytes = 0, n_start = 0, n_stop = 0;
  logic [7:0] got [64];

  always @(negedge clk) begin
    if (clr_ack != clr_req) begin
      clr_ack = clr_req;
      bitc = 0; acking = 1'b0; slv_pull = 1'b0; nbytes = 0;
    end
    if (scl_line && prev_scl && prev_sda && !sda_line) begin
      n_start++; bitc = 0; acking = 1'b0;
    end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
      n_stop++;
    end
    if (scl_line && !prev_scl && bitc < 8 && !acking) begin
      sh = {sh[6:0], sda_line}; bitc++;
    end
    if (!scl_line && prev_scl) begin
      if (acking) begin
        slv_pull = 1'b0; acking = 1'b0; bitc = 0;
      end else if (bitc == 8) begin
        if (nbytes < 64) got[nbytes] = sh;
        slv_pull = (nbytes != nak_at);
        nbytes++; acking = 1'b1;
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  function automatic logic [7:0] bval(input int i);
    return (i == 0) ? 8'hA4 : 8'(i * 37 + 11);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic wait_pend(input logic [6:0] mask, input int tries, output logic [31:0] d);
    for (int i = 0; i < tries; i++) begin
      rd(4'd3, d);
      if ((d[6:0] & mask) != 7'd0) break;
    end
  endtask

  task automatic slv_clear();
    clr_req++;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic fill(input int n);
    for (int w = 0; w < (n + 3) / 4; w++)
      wr(4'd8 + 4'(w), {bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)});
  endtask

  task automatic do_start();
    logic [31:0] d;
    wr(4'd0, 32'h1);
    wr(4'd0, 32'h9);
    wait_pend(7'h10, 400, d);
    wr(4'd0, 32'h1);
    wr(4'd3, 32'h7F);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd0, d); chk("R1 ctrl", d, 0);
    rd(4'd1, d); chk("R1 count", d, 0);
    rd(4'd2, d); chk("R1 ien", d, 0);
    rd(4'd3, d); chk("R1 pend", d, 0);
    chk("R1 lines", {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_start();
    logic [31:0] d;
    int s0;
    s0 = n_start;
    wr(4'd0, 32'h1);
    wr(4'd0, 32'h9);
    wait_pend(7'h10, 400, d);
    chk("R2 start pending", d & 32'h10, 32'h10);
    chk("R2 start seen", n_start - s0, 1);
    chk("R2 scl held low", scl_oe, 1);
    rd(4'd0, d); chk("R2 request bit kept", d, 32'h9);
    wr(4'd0, 32'h1);
    wr(4'd3, 32'h10);
    rd(4'd3, d); chk("R8 start cleared", d, 0);
  endtask

  task automatic t_burst(input int n);
    logic [31:0] d;
    slv_clear();
    fill(n);
    wr(4'd1, 32'(n));
    wait_pend(7'h44, 3000, d);
    chk("R3 pending byte+burst", d, 32'h05);
    chk("R3 byte count", nbytes, n);
    for (int i = 0; i < n; i++) chk("R3 byte data", got[i], bval(i));
    wr(4'd3, 32'h01);
    rd(4'd3, d); chk("R8 partial clear", d, 32'h04);
    wr(4'd3, 32'h04);
    rd(4'd3, d); chk("R8 full clear", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    slv_clear();
    fill(2);
    wr(4'd1, 32'd2);
    wait_pend(7'h04, 2000, d);
    repeat (3) @(negedge clk);
    chk("R9 no enable", irq, 0);
    wr(4'd2, 32'h40);
    repeat (3) @(negedge clk);
    chk("R9 other enable", irq, 0);
    wr(4'd2, 32'h04);
    repeat (3) @(negedge clk);
    chk("R9 enabled pending", irq, 1);
    wr(4'd3, 32'h05);
    repeat (3) @(negedge clk);
    chk("R9 cleared", irq, 0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_nak();
    logic [31:0] d;
    slv_clear();
    nak_at = 2;
    fill(5);
    wr(4'd1, 32'd5);
    wait_pend(7'h44, 3000, d);
    chk("R6 nak pending", d & 32'h44, 32'h40);
    chk("R6 bytes until nak", nbytes, 3);
    repeat (600) @(negedge clk);
    chk("R6 no more bytes", nbytes, 3);
    rd(4'd3, d); chk("R6 no burst done", d & 32'h04, 0);
    nak_at = -1;
    wr(4'd3, 32'h7F);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int s0;
    s0 = n_stop;
    wr(4'd0, 32'h11);
    wait_pend(7'h20, 400, d);
    chk("R7 stop pending", d & 32'h20, 32'h20);
    chk("R7 stop seen", n_stop - s0, 1);
    chk("R7 lines released", {scl_oe, sda_oe}, 0);
    wr(4'd0, 32'h1);
    wr(4'd3, 32'h7F);
  endtask

  task automatic t_cap();
    logic [31:0] d;
    do_start();
    slv_clear();
    fill(32);
    wr(4'd1, 32'd40);
    wait_pend(7'h44, 8000, d);
    chk("R5 capped pending", d, 32'h05);
    chk("R5 capped count", nbytes, 32);
    chk("R5 last byte", got[31], bval(31));
    wr(4'd3, 32'h7F);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    slv_clear();
    wr(4'd1, 32'd0);
    repeat (400) @(negedge clk);
    chk("R5 zero count bytes", nbytes, 0);
    rd(4'd3, d); chk("R5 zero count pending", d, 0);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    slv_clear();
    wr(4'd0, 32'h3);
    wr(4'd1, 32'd4);
    repeat (400) @(negedge clk);
    chk("R11 bytes", nbytes, 0);
    rd(4'd3, d); chk("R11 pending", d, 0);
    wr(4'd0, 32'h1);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    slv_clear();
    fill(8);
    wr(4'd1, 32'd8);
    repeat (300) @(negedge clk);
    wr(4'd0, 32'h0);
    chk("R10 lines released", {scl_oe, sda_oe}, 0);
    repeat (2500) @(negedge clk);
    rd(4'd3, d); chk("R10 no burst done", d & 32'h04, 0);
    chk("R10 lines idle", {scl_oe, sda_oe}, 0);
    rd(4'd0, d); chk("R10 ctrl zero", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start();
    t_burst(5);
    t_irq();
    t_nak();
    t_stop();
    t_cap();
    t_zero();
    t_mode();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule